// File: doc/BRIEF.md
# Five-Stage Forwarding RV32 Integer Pipeline

The core is an in-order, five-stage pipeline (fetch, decode, execute, memory, writeback) that runs an eleven-instruction integer subset of RV32I: add, sub, and, or, addi, andi, ori, lw, sw, beq and bge. Instruction and data live in two separate word arrays, so a fetch never competes with a load or a store. Four stage registers separate the five stages. Each decoded instruction carries a nine-bit control word that is picked from its instruction class (load, store, register ALU, immediate ALU, branch). An instruction outside the subset gets an all-zero word and passes through the pipeline as a no-op.

Results return to the execute stage from the memory and writeback stages, so dependent ALU instructions issue back to back. A load followed at once by an instruction that reads its destination holds fetch and decode for one cycle and inserts a bubble into execute. Branches resolve in execute. A taken branch discards the two younger instructions and redirects fetch.

Both arrays are written through a preload port while the core is held in reset. After the run, a register peek port and a data peek port read back the architectural state. The core is used as a small, testable execution engine whose programs are placed by its environment.

Top module: `rvp_pipe_core`

## Requirements
- R1: While `rst_n` is low, all general registers read zero and the pipeline holds no instruction. The first fetch after release is from byte address 0, taken at the first rising clock edge.
- R2: Register ALU instructions use opcode 0110011. The function fields are: add funct7 0000000 funct3 000, sub funct7 0100000 funct3 000, and funct3 111, or funct3 110. Each writes the 32-bit result to rd.
- R3: Immediate ALU instructions use opcode 0010011. The funct3 values are addi 000, andi 111 and ori 110. The operand is bits [31:20] of the instruction, sign-extended to 32 bits.
- R4: lw uses opcode 0000011 funct3 010 and sw uses opcode 0100011 funct3 010. The byte address is rs1 plus a sign-extended 12-bit offset. A load takes the offset from bits [31:20]; a store takes it from bits [31:25] joined to bits [11:7]. The word index is the address above bit 1. A store writes rs2.
- R5: Without a stall or a taken branch, the PC advances by 4 every cycle and a dependent ALU chain runs without waiting. The k-th instruction (counting from 0) of a stall-free program, if it is a store, is visible in data memory after rising edge k+4 following reset release.
- R6: When an instruction reads the destination of the load directly ahead of it, exactly one bubble is inserted and PC and fetch/decode are held for one cycle. The dependent instruction, including a store using the loaded value as data, sees the loaded word.
- R7: beq uses opcode 1100011 funct3 000 and tests equality. bge uses funct3 101 and tests signed greater-or-equal. A taken branch discards the two instructions behind it. The next fetch is at the branch address plus the B-format offset, assembled from bits [31], [7], [30:25], [11:8] and a zero bit 0, then sign-extended.
- R8: Register x0 always reads zero. An instruction with rd = x0 leaves every register unchanged and forwards nothing.
- R9: An instruction that reads a register written by the instruction three slots earlier sees the new value, because it reads in the cycle that value is written back.
- R10: An instruction with an unknown opcode, or a listed opcode with an unsupported funct3/funct7, has an all-zero control word. It changes no register and no memory word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_we | input | 1 | Preload write strobe for instruction memory |
| imem_waddr | input | 6 | Preload word index for instruction memory |
| imem_wdata | input | 32 | Preload instruction word |
| dmem_ld_we | input | 1 | Preload write strobe for data memory |
| dmem_ld_addr | input | 6 | Preload word index for data memory |
| dmem_ld_data | input | 32 | Preload data word |
| peek_reg_sel | input | 5 | Register number to read back |
| peek_reg_val | output | 32 | Current value of the selected register |
| peek_mem_addr | input | 6 | Data memory word index to read back |
| peek_mem_val | output | 32 | Current content of that data word |

## Verification
The hardest cases to reach from the ports depend on timing between instructions: a load whose value feeds the very next branch or store data, a chain whose producers sit one, two and three slots back, and an x0-writing instruction in flight while a later one reads x0. These arise only from particular instruction orders. The bench therefore assembles fixed programs that place them at known distances. It sweeps every pair from a set of edge operand values (zero, all ones, the signed extremes, a large pattern) through those programs. The final registers and memory are compared with a sequential instruction model kept in the bench. Separate short programs watch one memory word every cycle to pin down the exact edge at which a store lands with no hazard, with a load-use bubble, and behind a taken branch.

// File: rtl/rvp_pkg.sv
package rvp_pkg;

  localparam int XLEN = 32;

  // Nine-bit control word, most significant field first.
  typedef struct packed {
    logic       reg_rd;
    logic       alu_src;
    logic [1:0] alu_op;
    logic       mem_wr;
    logic       mem_rd;
    logic       reg_wr;
    logic       mem_to_reg;
    logic       branch;
  } ctrl_t;

  localparam ctrl_t CW_NONE  = 9'b0_0_00_0_0_0_0_0;
  localparam ctrl_t CW_LOAD  = 9'b1_1_00_0_1_1_1_0;
  localparam ctrl_t CW_STORE = 9'b1_1_00_1_0_0_0_0;
  localparam ctrl_t CW_RALU  = 9'b1_0_10_0_0_1_0_0;
  localparam ctrl_t CW_BRCH  = 9'b1_0_01_0_0_0_0_1;
  localparam ctrl_t CW_IALU  = 9'b1_1_11_0_0_1_0_0;

  localparam logic [6:0] OPC_RALU  = 7'b0110011;
  localparam logic [6:0] OPC_IALU  = 7'b0010011;
  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [6:0] OPC_STORE = 7'b0100011;
  localparam logic [6:0] OPC_BRCH  = 7'b1100011;

  function automatic logic [XLEN-1:0] imm_itype(input logic [31:0] ins);
    return {{20{ins[31]}}, ins[31:20]};
  endfunction

  function automatic logic [XLEN-1:0] imm_stype(input logic [31:0] ins);
    return {{20{ins[31]}}, ins[31:25], ins[11:7]};
  endfunction

  function automatic logic [XLEN-1:0] imm_btype(input logic [31:0] ins);
    return {{19{ins[31]}}, ins[31], ins[7], ins[30:25], ins[11:8], 1'b0};
  endfunction

  // ALU: op 00 address add, 01 compare-subtract, 10 register form, 11 immediate form
  function automatic logic [XLEN-1:0] alu_eval(input logic [1:0] op, input logic [2:0] f3,
                                               input logic f7b5, input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    logic [XLEN-1:0] r;
    r = '0;
    case (op)
      2'b00: r = a + b;
      2'b01: r = a - b;
      default: begin
        case (f3)
          3'b000:  r = (op == 2'b10 && f7b5) ? (a - b) : (a + b);
          3'b111:  r = a & b;
          3'b110:  r = a | b;
          default: r = '0;
        endcase
      end
    endcase
    return r;
  endfunction

  function automatic logic branch_holds(input logic [2:0] f3, input logic [XLEN-1:0] a,
                                        input logic [XLEN-1:0] b);
    return (f3 == 3'b000) ? (a == b) : ($signed(a) >= $signed(b));
  endfunction

endpackage

// File: rtl/rvp_decode.sv
module rvp_decode
  import rvp_pkg::*;
(
  input  logic [31:0]     instr,
  output ctrl_t           ctrl,
  output logic [XLEN-1:0] imm,
  output logic            use_rs1,
  output logic            use_rs2
);
  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;

  assign opc = instr[6:0];
  assign f3  = instr[14:12];
  assign f7  = instr[31:25];

  always_comb begin
    ctrl = CW_NONE;
    imm  = '0;
    case (opc)
      OPC_RALU:
        if ((f7 == 7'b0000000 && (f3 == 3'b000 || f3 == 3'b111 || f3 == 3'b110)) ||
            (f7 == 7'b0100000 && f3 == 3'b000))
          ctrl = CW_RALU;
      OPC_IALU:
        if (f3 == 3'b000 || f3 == 3'b111 || f3 == 3'b110) begin
          ctrl = CW_IALU;
          imm  = imm_itype(instr);
        end
      OPC_LOAD:
        if (f3 == 3'b010) begin
          ctrl = CW_LOAD;
          imm  = imm_itype(instr);
        end
      OPC_STORE:
        if (f3 == 3'b010) begin
          ctrl = CW_STORE;
          imm  = imm_stype(instr);
        end
      OPC_BRCH:
        if (f3 == 3'b000 || f3 == 3'b101) begin
          ctrl = CW_BRCH;
          imm  = imm_btype(instr);
        end
      default: ctrl = CW_NONE;
    endcase
  end

  assign use_rs1 = ctrl.reg_rd;
  assign use_rs2 = ctrl.reg_rd && (!ctrl.alu_src || ctrl.mem_wr);
endmodule

// File: rtl/rvp_regfile.sv
module rvp_regfile #(
  parameter int NREG = 32,
  parameter int XLEN = 32,
  localparam int AW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   wa,
  input  logic [XLEN-1:0] wd,
  input  logic [AW-1:0]   ra1,
  input  logic [AW-1:0]   ra2,
  input  logic [AW-1:0]   ra3,
  output logic [XLEN-1:0] rd1,
  output logic [XLEN-1:0] rd2,
  output logic [XLEN-1:0] rd3
);
  logic [XLEN-1:0] regs [NREG];
  logic            wr_live;

  assign wr_live = we && (wa != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_live) begin
      regs[wa] <= wd;
    end
  end

  // Write-through read: a same-cycle write is visible to the reader
  function automatic logic [XLEN-1:0] rd_port(input logic [AW-1:0] ra);
    if (ra == '0)               return '0;
    else if (wr_live && wa == ra) return wd;
    else                        return regs[ra];
  endfunction

  assign rd1 = rd_port(ra1);
  assign rd2 = rd_port(ra2);
  assign rd3 = rd_port(ra3);
endmodule

// File: rtl/rvp_hazard.sv
module rvp_hazard #(
  parameter int AW = 5
) (
  input  logic          ex_is_load,
  input  logic [AW-1:0] ex_rd,
  input  logic [AW-1:0] ex_rs1,
  input  logic [AW-1:0] ex_rs2,
  input  logic          id_use_rs1,
  input  logic          id_use_rs2,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          mem_reg_wr,
  input  logic [AW-1:0] mem_rd,
  input  logic          wb_reg_wr,
  input  logic [AW-1:0] wb_rd,
  output logic          stall_ld,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b
);
  // fwd code: 00 register read, 01 from memory stage, 10 from writeback stage
  function automatic logic [1:0] pick_src(input logic [AW-1:0] rs);
    if (mem_reg_wr && mem_rd != '0 && mem_rd == rs)     return 2'b01;
    else if (wb_reg_wr && wb_rd != '0 && wb_rd == rs)   return 2'b10;
    else                                                return 2'b00;
  endfunction

  assign fwd_a = pick_src(ex_rs1);
  assign fwd_b = pick_src(ex_rs2);

  assign stall_ld = ex_is_load && (ex_rd != '0) &&
                    ((id_use_rs1 && id_rs1 == ex_rd) || (id_use_rs2 && id_rs2 == ex_rd));
endmodule

// File: rtl/rvp_pipe_core.sv
module rvp_pipe_core
  import rvp_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int NREG       = 32,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS),
  localparam int RAW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            imem_we,
  input  logic [IAW-1:0]  imem_waddr,
  input  logic [31:0]     imem_wdata,
  input  logic            dmem_ld_we,
  input  logic [DAW-1:0]  dmem_ld_addr,
  input  logic [XLEN-1:0] dmem_ld_data,
  input  logic [RAW-1:0]  peek_reg_sel,
  output logic [XLEN-1:0] peek_reg_val,
  input  logic [DAW-1:0]  peek_mem_addr,
  output logic [XLEN-1:0] peek_mem_val
);
  logic [31:0]     imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  // ---------------- fetch ----------------
  logic [XLEN-1:0] pc_q;
  logic [31:0]     if_instr;
  assign if_instr = imem[pc_q[IAW+1:2]];

  // IF/ID
  logic [XLEN-1:0] ifid_pc;
  logic [31:0]     ifid_instr;

  // ---------------- decode ----------------
  ctrl_t           id_ctrl;
  logic [XLEN-1:0] id_imm, id_a, id_b;
  logic            id_use_rs1, id_use_rs2;
  logic [RAW-1:0]  id_rs1, id_rs2, id_rd;
  assign id_rs1 = ifid_instr[19:15];
  assign id_rs2 = ifid_instr[24:20];
  assign id_rd  = ifid_instr[11:7];

  rvp_decode u_dec (
    .instr(ifid_instr), .ctrl(id_ctrl), .imm(id_imm),
    .use_rs1(id_use_rs1), .use_rs2(id_use_rs2)
  );

  // ID/EX
  ctrl_t           idex_ctrl;
  logic [XLEN-1:0] idex_pc, idex_a, idex_b, idex_imm;
  logic [RAW-1:0]  idex_rs1, idex_rs2, idex_rd;
  logic [2:0]      idex_f3;
  logic            idex_f7b5;

  // EX/MEM and MEM/WB
  ctrl_t           exmem_ctrl, memwb_ctrl;
  logic [XLEN-1:0] exmem_alu, exmem_sdata, memwb_alu, memwb_rdata;
  logic [RAW-1:0]  exmem_rd, memwb_rd;

  // ---------------- writeback ----------------
  logic [XLEN-1:0] wb_value;
  assign wb_value = memwb_ctrl.mem_to_reg ? memwb_rdata : memwb_alu;

  rvp_regfile #(.NREG(NREG), .XLEN(XLEN)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(memwb_ctrl.reg_wr), .wa(memwb_rd), .wd(wb_value),
    .ra1(id_rs1), .ra2(id_rs2), .ra3(peek_reg_sel),
    .rd1(id_a), .rd2(id_b), .rd3(peek_reg_val)
  );

  // ---------------- hazards (named events) ----------------
  logic       stall_ld;
  logic [1:0] fwd_a, fwd_b;

  rvp_hazard #(.AW(RAW)) u_haz (
    .ex_is_load(idex_ctrl.mem_rd), .ex_rd(idex_rd),
    .ex_rs1(idex_rs1), .ex_rs2(idex_rs2),
    .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2),
    .id_rs1(id_rs1), .id_rs2(id_rs2),
    .mem_reg_wr(exmem_ctrl.reg_wr), .mem_rd(exmem_rd),
    .wb_reg_wr(memwb_ctrl.reg_wr), .wb_rd(memwb_rd),
    .stall_ld(stall_ld), .fwd_a(fwd_a), .fwd_b(fwd_b)
  );

  // ---------------- execute ----------------
  logic [XLEN-1:0] ex_a, ex_b, ex_opb, ex_alu, br_target;
  logic            br_taken;

  function automatic logic [XLEN-1:0] fwd_mux(input logic [1:0] sel, input logic [XLEN-1:0] rf);
    case (sel)
      2'b01:   return exmem_alu;
      2'b10:   return wb_value;
      default: return rf;
    endcase
  endfunction

  assign ex_a      = fwd_mux(fwd_a, idex_a);
  assign ex_b      = fwd_mux(fwd_b, idex_b);
  assign ex_opb    = idex_ctrl.alu_src ? idex_imm : ex_b;
  assign ex_alu    = alu_eval(idex_ctrl.alu_op, idex_f3, idex_f7b5, ex_a, ex_opb);
  assign br_taken  = idex_ctrl.branch && branch_holds(idex_f3, ex_a, ex_b);
  assign br_target = idex_pc + idex_imm;

  // ---------------- memory ----------------
  logic [XLEN-1:0] mem_rdata;
  assign mem_rdata    = dmem[exmem_alu[DAW+1:2]];
  assign peek_mem_val = dmem[peek_mem_addr];

  always_ff @(posedge clk) begin
    if (imem_we) imem[imem_waddr] <= imem_wdata;
  end

  always_ff @(posedge clk) begin
    if (dmem_ld_we)             dmem[dmem_ld_addr] <= dmem_ld_data;
    else if (exmem_ctrl.mem_wr) dmem[exmem_alu[DAW+1:2]] <= exmem_sdata;
  end

  // ---------------- stage registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q       <= '0;
      ifid_pc    <= '0;
      ifid_instr <= '0;
    end else if (br_taken) begin
      pc_q       <= br_target;
      ifid_instr <= '0;
    end else if (!stall_ld) begin
      pc_q       <= pc_q + XLEN'(4);
      ifid_pc    <= pc_q;
      ifid_instr <= if_instr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || 1'b0) begin
      idex_ctrl <= CW_NONE;
      idex_pc   <= '0;
      idex_a    <= '0;
      idex_b    <= '0;
      idex_imm  <= '0;
      idex_rs1  <= '0;
      idex_rs2  <= '0;
      idex_rd   <= '0;
      idex_f3   <= '0;
      idex_f7b5 <= 1'b0;
    end else if (br_taken || stall_ld) begin
      idex_ctrl <= CW_NONE;
      idex_rd   <= '0;
    end else begin
      idex_ctrl <= id_ctrl;
      idex_pc   <= ifid_pc;
      idex_a    <= id_a;
      idex_b    <= id_b;
      idex_imm  <= id_imm;
      idex_rs1  <= id_rs1;
      idex_rs2  <= id_rs2;
      idex_rd   <= id_rd;
      idex_f3   <= ifid_instr[14:12];
      idex_f7b5 <= ifid_instr[30];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exmem_ctrl  <= CW_NONE;
      exmem_alu   <= '0;
      exmem_sdata <= '0;
      exmem_rd    <= '0;
      memwb_ctrl  <= CW_NONE;
      memwb_alu   <= '0;
      memwb_rdata <= '0;
      memwb_rd    <= '0;
    end else begin
      exmem_ctrl  <= idex_ctrl;
      exmem_alu   <= ex_alu;
      exmem_sdata <= ex_b;
      exmem_rd    <= idex_rd;
      memwb_ctrl  <= exmem_ctrl;
      memwb_alu   <= exmem_alu;
      memwb_rdata <= mem_rdata;
      memwb_rd    <= exmem_rd;
    end
  end
endmodule

// File: rtl/rvp_core_checker.sv
module rvp_core_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] pc,
  input logic        stall_ld,
  input logic        br_taken,
  input logic [31:0] br_target,
  input logic [8:0]  id_ctrl,
  input logic [8:0]  idex_ctrl,
  input logic [4:0]  peek_reg_sel,
  input logic [31:0] peek_reg_val
);
  assert_pc_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_ld && !br_taken) |=> (pc == $past(pc) + 32'd4));

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_ld && !br_taken) |=> (pc == $past(pc)));

  assert_stall_bubble_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall_ld |=> (idex_ctrl == 9'd0));

  assert_branch_redirect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |=> (pc == $past(br_target) && idex_ctrl == 9'd0));

  assert_ctrl_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (id_ctrl == 9'b000000000 || id_ctrl == 9'b110001110 || id_ctrl == 9'b110010000 ||
     id_ctrl == 9'b101000100 || id_ctrl == 9'b100100001 || id_ctrl == 9'b111100100));

  assert_x0_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (peek_reg_sel == 5'd0) |-> (peek_reg_val == 32'd0));
endmodule

bind rvp_pipe_core rvp_core_checker u_rvp_core_checker (
  .clk(clk), .rst_n(rst_n), .pc(pc_q), .stall_ld(stall_ld),
  .br_taken(br_taken), .br_target(br_target),
  .id_ctrl(id_ctrl), .idex_ctrl(idex_ctrl),
  .peek_reg_sel(peek_reg_sel), .peek_reg_val(peek_reg_val)
);

// File: tb/test_rvp_pipe_core.sv
module test_rvp_pipe_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imem_we = 1'b0;
  logic [5:0]  imem_waddr = '0;
  logic [31:0] imem_wdata = '0;
  logic        dmem_ld_we = 1'b0;
  logic [5:0]  dmem_ld_addr = '0;
  logic [31:0] dmem_ld_data = '0;
  logic [4:0]  peek_reg_sel = '0;
  logic [31:0] peek_reg_val;
  logic [5:0]  peek_mem_addr = '0;
  logic [31:0] peek_mem_val;

  always #2 clk = ~clk;   // 250 MHz

  rvp_pipe_core i_rvp_pipe_core (
    .clk(clk), .rst_n(rst_n),
    .imem_we(imem_we), .imem_waddr(imem_waddr), .imem_wdata(imem_wdata),
    .dmem_ld_we(dmem_ld_we), .dmem_ld_addr(dmem_ld_addr), .dmem_ld_data(dmem_ld_data),
    .peek_reg_sel(peek_reg_sel), .peek_reg_val(peek_reg_val),
    .peek_mem_addr(peek_mem_addr), .peek_mem_val(peek_mem_val)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  logic [31:0] prog  [64];
  logic [31:0] dinit [64];
  logic [31:0] exp_rf [32];
  logic [31:0] exp_dm [64];

  localparam logic [31:0] HALT = 32'h0000_0063;  // beq x0,x0,0

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // ---- encoders ----
  function automatic logic [31:0] e_r(input logic [6:0] f7, input int rs2, input int rs1,
                                      input logic [2:0] f3, input int rd);
    return {f7, 5'(rs2), 5'(rs1), f3, 5'(rd), 7'b0110011};
  endfunction
  function automatic logic [31:0] e_i(input int imm, input int rs1, input logic [2:0] f3,
                                      input int rd, input logic [6:0] opc);
    logic [11:0] v = 12'(imm);
    return {v, 5'(rs1), f3, 5'(rd), opc};
  endfunction
  function automatic logic [31:0] e_s(input int imm, input int rs2, input int rs1);
    logic [11:0] v = 12'(imm);
    return {v[11:5], 5'(rs2), 5'(rs1), 3'b010, v[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] e_b(input int off, input int rs2, input int rs1,
                                      input logic [2:0] f3);
    logic [12:0] v = 13'(off);
    return {v[12], v[10:5], 5'(rs2), 5'(rs1), f3, v[4:1], v[11], 7'b1100011};
  endfunction

  // ---- sequential reference model ----
  task automatic iss_run();
    logic [31:0] r [32];
    logic [31:0] pc, ins, a, b, res, nxt, addr;
    logic [6:0]  op, f7;
    logic [2:0]  f3;
    bit          wr;
    for (int i = 0; i < 32; i++) r[i] = '0;
    for (int i = 0; i < 64; i++) exp_dm[i] = dinit[i];
    pc = '0;
    for (int s = 0; s < 600; s++) begin
      ins = prog[pc[7:2]];
      if (ins == HALT) break;
      op = ins[6:0]; f3 = ins[14:12]; f7 = ins[31:25];
      a = r[ins[19:15]]; b = r[ins[24:20]];
      nxt = pc + 4; wr = 0; res = '0;
      if (op == 7'h33) begin
        if (f7 == 7'h00 && f3 == 3'd0) begin res = a + b; wr = 1; end
        if (f7 == 7'h20 && f3 == 3'd0) begin res = a - b; wr = 1; end
        if (f7 == 7'h00 && f3 == 3'd7) begin res = a & b; wr = 1; end
        if (f7 == 7'h00 && f3 == 3'd6) begin res = a | b; wr = 1; end
      end else if (op == 7'h13) begin
        b = 32'(signed'(ins[31:20]));
        if (f3 == 3'd0) begin res = a + b; wr = 1; end
        if (f3 == 3'd7) begin res = a & b; wr = 1; end
        if (f3 == 3'd6) begin res = a | b; wr = 1; end
      end else if (op == 7'h03 && f3 == 3'd2) begin
        addr = a + 32'(signed'(ins[31:20]));
        res = exp_dm[addr[7:2]]; wr = 1;
      end else if (op == 7'h23 && f3 == 3'd2) begin
        addr = a + 32'(signed'({ins[31:25], ins[11:7]}));
        exp_dm[addr[7:2]] = b;
      end else if (op == 7'h63) begin
        if ((f3 == 3'd0 && a == b) || (f3 == 3'd5 && $signed(a) >= $signed(b)))
          nxt = pc + 32'(signed'({ins[31], ins[7], ins[30:25], ins[11:8], 1'b0}));
      end
      if (wr && ins[11:7] != 5'd0) r[ins[11:7]] = res;
      pc = nxt;
    end
    for (int i = 0; i < 32; i++) exp_rf[i] = r[i];
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) begin prog[i] = HALT; dinit[i] = '0; end
  endtask

  // Reset, preload both memories, release reset at a falling edge
  task automatic load_and_start();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 64; i++) begin
      imem_we = 1'b1; imem_waddr = 6'(i); imem_wdata = prog[i];
      dmem_ld_we = 1'b1; dmem_ld_addr = 6'(i); dmem_ld_data = dinit[i];
      @(negedge clk);
    end
    imem_we = 1'b0; dmem_ld_we = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic reg_chk(input string tag, input int r);
    peek_reg_sel = 5'(r);
    #1;
    chk(tag, $sformatf("x%0d", r), peek_reg_val, exp_rf[r]);
  endtask

  task automatic mem_chk(input string tag, input int w);
    peek_mem_addr = 6'(w);
    #1;
    chk(tag, $sformatf("dmem[%0d]", w), peek_mem_val, exp_dm[w]);
  endtask

  // ALU / forwarding / load-use / x0 / bypass / no-op program
  task automatic build_alu(input logic [31:0] va, input logic [31:0] vb);
    clear_prog();
    dinit[0] = va; dinit[1] = vb;
    prog[0]  = e_i(0, 0, 3'b010, 1, 7'b0000011);      // lw x1,0(x0)
    prog[1]  = e_i(4, 0, 3'b010, 2, 7'b0000011);      // lw x2,4(x0)
    prog[2]  = e_r(7'h00, 2, 1, 3'b000, 3);           // add x3  (load-use)
    prog[3]  = e_r(7'h20, 2, 1, 3'b000, 4);           // sub x4
    prog[4]  = e_r(7'h00, 2, 1, 3'b111, 5);           // and x5
    prog[5]  = e_r(7'h00, 2, 1, 3'b110, 6);           // or  x6
    prog[6]  = e_i(-5, 1, 3'b000, 7, 7'b0010011);     // addi x7,x1,-5
    prog[7]  = e_i(240, 2, 3'b111, 8, 7'b0010011);    // andi x8,x2,0xf0
    prog[8]  = e_i(-2048, 1, 3'b110, 9, 7'b0010011);  // ori  x9,x1,-2048
    prog[9]  = e_r(7'h00, 8, 9, 3'b000, 10);          // add x10,x9,x8
    prog[10] = e_r(7'h20, 7, 10, 3'b000, 11);         // sub x11,x10,x7
    prog[11] = e_r(7'h00, 10, 11, 3'b110, 12);        // or  x12,x11,x10
    prog[12] = e_i(5, 11, 3'b000, 0, 7'b0010011);     // addi x0,x11,5
    prog[13] = e_r(7'h00, 10, 0, 3'b000, 13);         // add x13,x0,x10
    prog[14] = e_r(7'h00, 12, 11, 3'b111, 14);        // and x14,x11,x12 (x12 three back)
    prog[15] = e_s(8, 14, 0);                         // sw x14,8(x0)
    prog[16] = e_s(12, 13, 0);                        // sw x13,12(x0)
    prog[17] = {7'h00, 5'd1, 5'd1, 3'b000, 5'd11, 7'b1111111};  // unknown opcode
    prog[18] = e_r(7'h00, 1, 1, 3'b001, 12);          // unsupported funct3
    prog[19] = e_i(8, 0, 3'b010, 15, 7'b0000011);     // lw x15,8(x0)
    prog[20] = e_s(16, 15, 0);                        // sw x15,16(x0) (load-use data)
  endtask

  // Branch program: forward skips and a counted backward loop
  task automatic build_br(input logic [31:0] va, input logic [31:0] vb);
    clear_prog();
    dinit[0] = va; dinit[1] = vb;
    prog[0]  = e_i(0, 0, 3'b010, 1, 7'b0000011);
    prog[1]  = e_i(4, 0, 3'b010, 2, 7'b0000011);
    prog[2]  = e_b(8, 2, 1, 3'b101);                  // bge x1,x2,+8
    prog[3]  = e_i(1, 0, 3'b000, 16, 7'b0010011);
    prog[4]  = e_i(2, 0, 3'b000, 17, 7'b0010011);
    prog[5]  = e_b(12, 2, 1, 3'b000);                 // beq x1,x2,+12
    prog[6]  = e_i(3, 0, 3'b000, 18, 7'b0010011);
    prog[7]  = e_i(4, 0, 3'b000, 19, 7'b0010011);
    prog[8]  = e_i(0, 0, 3'b000, 20, 7'b0010011);
    prog[9]  = e_i(3, 0, 3'b000, 21, 7'b0010011);
    prog[10] = e_i(1, 20, 3'b000, 20, 7'b0010011);    // loop body
    prog[11] = e_b(-4, 20, 21, 3'b101);               // bge x21,x20,-4
    prog[12] = e_i(10, 20, 3'b000, 22, 7'b0010011);
    prog[13] = e_s(20, 20, 0);
  endtask

  // Watch dmem word 10 and report the rising edge at which it first becomes nonzero
  task automatic timed_run(input string tag, input int exp_edge, input logic [31:0] exp_val);
    int first = 0;
    logic [31:0] seen = '0;
    peek_mem_addr = 6'd10;
    load_and_start();
    for (int e = 1; e <= 40; e++) begin
      @(negedge clk);
      if (first == 0 && peek_mem_val != 0) begin first = e; seen = peek_mem_val; end
    end
    chk(tag, "store landing edge", 32'(first), 32'(exp_edge));
    chk(tag, "stored value", seen, exp_val);
  endtask

  logic [31:0] vals [8];

  initial begin
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'hFFFF_FFFF;
    vals[3] = 32'h0000_0007; vals[4] = 32'h7FFF_FFFF; vals[5] = 32'h8000_0000;
    vals[6] = 32'h1234_5678; vals[7] = 32'hFFFF_F800;

    // ALU sweep over all operand pairs
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        build_alu(vals[i], vals[j]);
        iss_run();
        load_and_start();
        repeat (60) @(negedge clk);
        reg_chk("R4", 1);  reg_chk("R4", 2);
        reg_chk("R2 R6", 3);
        reg_chk("R2", 4);  reg_chk("R2", 5);  reg_chk("R2", 6);
        reg_chk("R3", 7);  reg_chk("R3", 8);  reg_chk("R3", 9);
        reg_chk("R5", 10);
        reg_chk("R5 R10", 11); reg_chk("R5 R10", 12);
        reg_chk("R8", 13); reg_chk("R8", 0);
        reg_chk("R9", 14);
        reg_chk("R6", 15);
        mem_chk("R4", 0); mem_chk("R4", 1); mem_chk("R4", 2); mem_chk("R4", 3);
        mem_chk("R6", 4); mem_chk("R10", 5);
      end
    end

    // Reset clears every register (R1)
    @(negedge clk);
    rst_n = 1'b0;
    for (int r = 0; r < 32; r++) begin
      peek_reg_sel = 5'(r);
      #1;
      chk("R1", $sformatf("x%0d in reset", r), peek_reg_val, 32'd0);
    end

    // Branch sweep
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        build_br(vals[i], vals[j]);
        iss_run();
        load_and_start();
        repeat (80) @(negedge clk);
        for (int r = 16; r <= 22; r++) reg_chk("R7", r);
        mem_chk("R7", 5);
      end
    end

    // Timing: stall-free chain, first fetch at 0, store index 3 lands after edge 7
    clear_prog();
    prog[0] = e_i(5, 0, 3'b000, 1, 7'b0010011);
    prog[1] = e_i(3, 1, 3'b000, 2, 7'b0010011);
    prog[2] = e_r(7'h00, 1, 2, 3'b000, 3);
    prog[3] = e_s(40, 3, 0);
    timed_run("R1 R5", 7, 32'd13);

    // Timing: one load-use bubble
    clear_prog();
    dinit[0] = 32'd9;
    prog[0] = e_i(0, 0, 3'b010, 1, 7'b0000011);
    prog[1] = e_i(1, 1, 3'b000, 2, 7'b0010011);
    prog[2] = e_s(40, 2, 0);
    timed_run("R6", 7, 32'd10);

    // Timing: taken branch over two instructions
    clear_prog();
    prog[0] = e_b(12, 0, 0, 3'b000);
    prog[1] = e_i(1, 0, 3'b000, 5, 7'b0010011);
    prog[2] = e_i(1, 0, 3'b000, 7, 7'b0010011);
    prog[3] = e_i(7, 0, 3'b000, 6, 7'b0010011);
    prog[4] = e_s(40, 6, 0);
    timed_run("R7", 8, 32'd7);
    iss_run();
    reg_chk("R7", 5); reg_chk("R7", 7); reg_chk("R7", 6);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule